// File: doc/BRIEF.md
# Shift-Register Expansion Port Controller

This block runs a small expansion port built from external shift registers. A 16-bit output chain is made of two cascaded 8-bit serial-in parallel-out stages. One 8-bit parallel-in serial-out register captures the input pins. A single start strobe from the processor runs one complete exchange, so one instruction writes all 16 outputs and reads all 8 inputs. The exchange has five phases:

1. It pulses the input capture strobe.
2. It issues 16 shift clocks on a clock line shared by both chains, sending the output word most significant bit first and collecting the incoming serial bits.
3. It pulses the output update strobe, so that every output pin changes at the same moment.
4. It signals completion for one cycle.
5. It returns to idle.

The controller has six states:

- `ST_IDLE`: waiting for a command.
- `ST_CAPTURE`: input strobe high for one cycle.
- `ST_LOW`: shift clock low; the serial output bit is valid and the serial input is sampled as the state is left.
- `ST_HIGH`: shift clock high; the output bit is held.
- `ST_UPDATE`: output strobe high for one cycle.
- `ST_FINISH`: done high for one cycle.

The transitions are:

- `ST_IDLE` goes to `ST_CAPTURE` when start is high.
- `ST_CAPTURE` goes to `ST_LOW`.
- `ST_LOW` goes to `ST_HIGH`.
- `ST_HIGH` goes to `ST_LOW` while bits remain, and to `ST_UPDATE` after the last bit.
- `ST_UPDATE` goes to `ST_FINISH`.
- `ST_FINISH` goes to `ST_IDLE`.

Each bit takes two system clocks, and a whole exchange takes 35 cycles after the start cycle.

Top module: `srport_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, busy, done, port_sck, port_sdo, port_in_latch and port_out_latch are 0 and rx_byte is 0.
- R2: A start sampled high in idle makes port_in_latch high for exactly the next cycle. busy goes high in that same cycle.
- R3: After the capture cycle, 16 shift clock pulses follow. Each pulse is low for one cycle and then high for one cycle. No other strobe or done is high while port_sck is high.
- R4: port_sdo carries tx_word (the value sampled with start) most significant bit first, one bit per clock pulse. It changes only when the clock line enters the low phase, and it is 0 outside the shifting phases. After the exchange, a 16-bit serial-in parallel-out chain clocked on port_sck rising edges holds tx_word.
- R5: port_sdi is sampled at the system clock edge where port_sck rises. The first 8 samples form rx_byte, and the first sample lands in bit 7. The remaining 8 samples are ignored.
- R6: port_out_latch is high for exactly one cycle, directly after the high phase of the 16th clock pulse.
- R7: done is high for exactly one cycle, directly after the port_out_latch cycle. busy stays high from the capture cycle through the done cycle and is low otherwise.
- R8: start is ignored while busy is high, including in the done cycle. A start held high for many cycles produces back-to-back exchanges with exactly one idle cycle between them.
- R9: rx_byte keeps the captured input byte from the done cycle until the next exchange begins shifting, whatever the input pins do meanwhile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an exchange (sampled in idle) |
| tx_word | input | 16 | Output value, sampled with start |
| rx_byte | output | 8 | Captured input byte |
| busy | output | 1 | Exchange in progress |
| done | output | 1 | One-cycle completion pulse |
| port_sck | output | 1 | Shift clock shared by both chains |
| port_sdo | output | 1 | Serial data to the output chain |
| port_sdi | input | 1 | Serial data from the input register |
| port_in_latch | output | 1 | Parallel capture strobe for the input register |
| port_out_latch | output | 1 | Update strobe for the output chain |

## Verification
The hardest situations to reach from the ports are those where start is high at moments the controller must not act on it: mid-exchange, and in the done cycle itself. The stimulus holds start high across entire exchanges and releases it at arbitrary points. The cycle model then shows that only one capture pulse occurs per exchange and that a new exchange begins only after the single idle cycle. The bench also models the external input register and output chain, so the bit order is checked through what those parts actually hold. Changing the pins after capture and waiting many idle cycles shows the held input byte does not move.

// File: rtl/srport_pkg.sv
package srport_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CAPTURE,
        ST_LOW,
        ST_HIGH,
        ST_UPDATE,
        ST_FINISH
    } srport_state_e;
endpackage

// File: rtl/srport_fsm.sv
module srport_fsm
    import srport_pkg::*;
#(
    parameter int OUT_W = 16,
    localparam int CW = (OUT_W > 1) ? $clog2(OUT_W) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic [CW-1:0] bit_idx,
    output logic          load,
    output logic          shift,
    output logic          sample,
    output logic          drive,
    output logic          sck,
    output logic          in_latch,
    output logic          out_latch,
    output logic          done,
    output logic          busy
);
    srport_state_e state, nxt;
    logic          last_bit;

    assign last_bit = (bit_idx == CW'(OUT_W - 1));

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (start) nxt = ST_CAPTURE;
            ST_CAPTURE: nxt = ST_LOW;
            ST_LOW:     nxt = ST_HIGH;
            ST_HIGH:    nxt = last_bit ? ST_UPDATE : ST_LOW;
            ST_UPDATE:  nxt = ST_FINISH;
            ST_FINISH:  nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bit_idx <= '0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE && start)
                bit_idx <= '0;
            else if (state == ST_HIGH && !last_bit)
                bit_idx <= bit_idx + 1'b1;
        end
    end

    always_comb begin
        load      = 1'b0;
        shift     = 1'b0;
        sample    = 1'b0;
        drive     = 1'b0;
        sck       = 1'b0;
        in_latch  = 1'b0;
        out_latch = 1'b0;
        done      = 1'b0;
        busy      = 1'b1;
        unique case (state)
            ST_IDLE: begin
                busy = 1'b0;
                load = start;
            end
            ST_CAPTURE: in_latch = 1'b1;
            ST_LOW: begin
                drive  = 1'b1;
                sample = 1'b1;
            end
            ST_HIGH: begin
                drive = 1'b1;
                sck   = 1'b1;
                shift = 1'b1;
            end
            ST_UPDATE: out_latch = 1'b1;
            ST_FINISH: done = 1'b1;
            default:   busy = 1'b0;
        endcase
    end

    // R2
    capture_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_latch |-> ($past(start) && !$past(busy)));

    // R6
    update_after_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_latch |-> $past(sck));

    // R7
    done_after_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(out_latch));

    // R3
    strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sck, in_latch, out_latch, done}));
endmodule

// File: rtl/srport_txshift.sv
module srport_txshift #(
    parameter int OUT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             shift,
    input  logic [OUT_W-1:0] word,
    output logic             msb
);
    logic [OUT_W-1:0] shreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            shreg <= '0;
        else if (load)
            shreg <= word;
        else if (shift)
            shreg <= {shreg[OUT_W-2:0], 1'b0};
    end

    assign msb = shreg[OUT_W-1];
endmodule

// File: rtl/srport_rxshift.sv
module srport_rxshift #(
    parameter int OUT_W = 16,
    parameter int IN_W  = 8,
    localparam int CW = (OUT_W > 1) ? $clog2(OUT_W) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sample,
    input  logic [CW-1:0]   bit_idx,
    input  logic            sdi,
    output logic [IN_W-1:0] byte_o
);
    logic keep;

    assign keep = sample && (int'(bit_idx) < IN_W);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            byte_o <= '0;
        else if (keep)
            byte_o <= {byte_o[IN_W-2:0], sdi};
    end
endmodule

// File: rtl/srport_ctrl.sv
module srport_ctrl #(
    parameter int OUT_W = 16,
    parameter int IN_W  = 8,
    localparam int CW = (OUT_W > 1) ? $clog2(OUT_W) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [OUT_W-1:0] tx_word,
    output logic [IN_W-1:0]  rx_byte,
    output logic             busy,
    output logic             done,
    output logic             port_sck,
    output logic             port_sdo,
    input  logic             port_sdi,
    output logic             port_in_latch,
    output logic             port_out_latch
);
    logic [CW-1:0] bit_idx;
    logic          load, shift, sample, drive, tx_msb;

    srport_fsm #(.OUT_W(OUT_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .bit_idx   (bit_idx),
        .load      (load),
        .shift     (shift),
        .sample    (sample),
        .drive     (drive),
        .sck       (port_sck),
        .in_latch  (port_in_latch),
        .out_latch (port_out_latch),
        .done      (done),
        .busy      (busy)
    );

    srport_txshift #(.OUT_W(OUT_W)) u_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .shift (shift),
        .word  (tx_word),
        .msb   (tx_msb)
    );

    srport_rxshift #(.OUT_W(OUT_W), .IN_W(IN_W)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .sample  (sample),
        .bit_idx (bit_idx),
        .sdi     (port_sdi),
        .byte_o  (rx_byte)
    );

    assign port_sdo = drive & tx_msb;

    // R4
    sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        port_sck |-> $stable(port_sdo));

    // R9
    rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy)) |-> $stable(rx_byte));
endmodule

// File: tb/sim_srport_ctrl.sv
module sim_srport_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] tx_word = '0;
    logic [7:0]  rx_byte;
    logic        busy, done, port_sck, port_sdo, port_sdi, port_in_latch, port_out_latch;

    srport_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .tx_word(tx_word), .rx_byte(rx_byte),
        .busy(busy), .done(done), .port_sck(port_sck), .port_sdo(port_sdo),
        .port_sdi(port_sdi), .port_in_latch(port_in_latch), .port_out_latch(port_out_latch)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // external parts
    logic [7:0]  ext_in = '0;
    logic [7:0]  in_chain = '0;
    logic [15:0] out_chain = '0;
    logic [15:0] out_pins = '0;
    logic        sck_prev = 1'b0;
    logic        olat_prev = 1'b0;
    assign port_sdi = in_chain[7];

    // reference model state
    int          mstep = -1;
    logic [15:0] mtx = '0;
    logic [7:0]  mlatched = '0;
    logic [7:0]  mrx = '0;
    logic [15:0] mpins = '0;
    int          cap_pulses = 0;
    logic        reset_checked = 1'b0;

    always @(negedge clk) begin
        // external shift register behaviour
        if (port_in_latch) in_chain = ext_in;
        else if (port_sck && !sck_prev) in_chain = {in_chain[6:0], 1'b0};
        if (port_sck && !sck_prev) out_chain = {out_chain[14:0], port_sdo};
        if (port_out_latch && !olat_prev) out_pins = out_chain;
        sck_prev = port_sck;
        olat_prev = port_out_latch;
        if (port_in_latch) cap_pulses++;

        // model advance using inputs sampled at the previous posedge
        if (!rst_n) begin
            mstep = -1;
            mrx = '0;
        end else if (mstep == -1) begin
            if (start) begin
                mstep = 0;
                mtx = tx_word;
            end
        end else if (mstep == 34) begin
            mstep = -1;
        end else begin
            mstep++;
        end
        if (mstep == 0) mlatched = ext_in;
        if (mstep == 34) begin
            mrx = mlatched;
            mpins = mtx;
        end

        // compare
        chk("R7 busy", busy, mstep != -1);
        chk("R2 in_latch", port_in_latch, mstep == 0);
        chk("R3 sck", port_sck, (mstep >= 1 && mstep <= 32 && ((mstep - 1) % 2 == 1)));
        chk("R4 sdo", port_sdo,
            (mstep >= 1 && mstep <= 32) ? mtx[15 - (mstep - 1) / 2] : 1'b0);
        chk("R6 out_latch", port_out_latch, mstep == 33);
        chk("R7 done", done, mstep == 34);
        if (mstep == -1 || mstep == 34) begin
            chk("R5 rx_byte", rx_byte, mrx);
            chk("R4 out_pins", out_pins, mpins);
        end
    end

    task automatic wait_cycles(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic run_op(logic [15:0] w, logic [7:0] pins);
        @(negedge clk); #1;
        tx_word = w;
        ext_in  = pins;
        start   = 1'b1;
        @(negedge clk); #1;
        start   = 1'b0;
        tx_word = ~w;
        while (!done) @(negedge clk);
        #1;
        chk("R5 byte at done", rx_byte, pins);
        chk("R4 chain at done", out_pins, w);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wait_cycles(3);
        // R1 reset state
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 pins", {port_sck, port_sdo, port_in_latch, port_out_latch}, 0);
        chk("R1 rx", rx_byte, 0);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", {busy, done, port_sck, port_sdo}, 0);

        run_op(16'hA5C3, 8'h3C);
        run_op(16'hFFFF, 8'h00);
        run_op(16'h0001, 8'hFF);
        run_op(16'h8000, 8'h81);

        // R9 rx held while input pins move in idle
        ext_in = 8'h55;
        wait_cycles(20);
        chk("R9 rx held", rx_byte, 8'h81);

        // R8 start held across a whole exchange and past done
        cap_pulses = 0;
        @(negedge clk); #1;
        tx_word = 16'h1234;
        ext_in = 8'hC6;
        start = 1'b1;
        wait_cycles(30);
        #1 tx_word = 16'hFFFF;
        wait_cycles(10);
        #1 start = 1'b0;
        while (busy) @(negedge clk);
        wait_cycles(2);
        chk("R8 capture pulse count", cap_pulses, 2);
        chk("R8 final chain", out_pins, 16'hFFFF);

        run_op(16'h5A5A, 8'hA7);
        wait_cycles(5);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule